// File: doc/BRIEF.md
# Four-Channel Word Copy DMA

This block moves blocks of 32-bit words from one memory region to another on behalf of up to four independent software channels. Each channel owns a small bank of registers: where to copy to, where to copy from, how many bytes, a direction selector, an enable, a start flag, and two stored-only fields (trigger select and suspend). Software fills in a channel and then writes a nonzero value to its start field. A single copy engine serves one channel at a time. When more than one channel is waiting, the engine takes the lowest-numbered channel first.

The engine reads one word and then writes that word, then moves on to the next. When a channel's byte count is used up, the engine writes the final addresses back into the channel's registers. It also clears the length and start fields and pulses that channel's completion interrupt for a single cycle. Bit 31 of the length field is not part of the count. When it is set, the channel's enable is forced on at completion, so the channel stays armed for the next start.

The memory side uses valid/ready handshakes. A read request is held until it is accepted. Exactly one cycle later the memory answers with a read-data valid strobe, which has no back-pressure. A write request is held until the memory accepts it.

Top module: `word_copy_dma`

## Requirements
- R1: After reset, every register field of every channel reads 0, all interrupt lines are low, and no memory request is raised.
- R2: The register address is {channel, field}, with the field in bits [2:0]. The field codes are:
  - 0: target address
  - 1: source address
  - 2: length
  - 3: direction
  - 4: trigger select
  - 5: enable
  - 6: start
  - 7: suspend

  Target, source and length read back as written. Direction, trigger select and suspend read back as 1 for any nonzero write. Enable stores bit 0 of the written data.
- R3: A nonzero write to start sets the channel's start flag only when its enable reads 1 and its direction reads 0. Any other start write leaves the flag at 0 and causes no memory traffic and no interrupt.
- R4: A started transfer reads a word at the source address and then writes it to the target address. Both addresses advance by 4 per word. Read and write requests are never raised together.
- R5: The word count is length bits [30:0] divided by 4 and rounded up. At completion the target and source fields hold their start values plus 4 × words, length reads 0, and start reads 0.
- R6: If length bit 31 was set when the transfer began, enable reads 1 after completion. Otherwise enable keeps whatever value it held.
- R7: Completion raises exactly that channel's interrupt for one cycle. In that same cycle the register fields first show the completion values.
- R8: A byte count of 0 completes with no memory traffic and leaves both address fields unchanged.
- R9: Only one channel transfers at a time. Among waiting channels the lowest-numbered one is served next, so at most one interrupt line is high in any cycle.
- R10: While a channel is transferring, its register fields read the values they held when the transfer began.
- R11: A read or write request that is not accepted stays raised, with address (and write data) unchanged, in the next cycle.
- R12: Suppose a software write lands in the same cycle as a completion write-back. The write-back wins on the fields it updates. A start write to a different channel in that cycle is still recorded and served afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | {channel, field} register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rdata_valid | input | 1 | Read data strobe, one cycle after acceptance |
| mem_rdata | input | 32 | Read data |
| mem_wr_valid | output | 1 | Write request valid |
| mem_wr_ready | input | 1 | Write request accepted |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 32 | Write data |
| irq | output | 4 | Per-channel completion pulse |

## Verification
The two functions that can collide are the completion write-back of the active channel and a software register write that arrives in the same cycle.

The bench provokes this by watching the memory port for acceptance of the final word's write. It then places a register write exactly in the following cycle, which is the cycle in which write-back occurs.

In one run, that write targets the completing channel's source field. The bench expects the advanced address to survive.

In the other run, the write starts a second, already-enabled channel. The bench expects that channel to be served after the first one completes, with its data landing at the right place.

// File: rtl/wcd_pkg.sv
package wcd_pkg;
  localparam int FLD_W = 3;

  localparam logic [FLD_W-1:0] FLD_TGT = 3'd0;
  localparam logic [FLD_W-1:0] FLD_SRC = 3'd1;
  localparam logic [FLD_W-1:0] FLD_LEN = 3'd2;
  localparam logic [FLD_W-1:0] FLD_DIR = 3'd3;
  localparam logic [FLD_W-1:0] FLD_TRG = 3'd4;
  localparam logic [FLD_W-1:0] FLD_ENA = 3'd5;
  localparam logic [FLD_W-1:0] FLD_GO  = 3'd6;
  localparam logic [FLD_W-1:0] FLD_SUS = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_WR,
    ST_DONE
  } eng_state_t;
endpackage

// File: rtl/wcd_chan_regs.sv
module wcd_chan_regs
  import wcd_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [FLD_W-1:0] fld,
  input  logic [DW-1:0]    wdata,
  input  logic             done,
  input  logic [AW-1:0]    fin_src,
  input  logic [AW-1:0]    fin_dst,
  input  logic             keep,
  output logic [AW-1:0]    tgt,
  output logic [AW-1:0]    src,
  output logic [DW-1:0]    len,
  output logic             go,
  output logic [DW-1:0]    rdata,
  output logic             irq
);
  logic dir_q, trg_q, ena_q, sus_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt   <= '0;
      src   <= '0;
      len   <= '0;
      go    <= 1'b0;
      dir_q <= 1'b0;
      trg_q <= 1'b0;
      ena_q <= 1'b0;
      sus_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= done;
      if (wr_en) begin
        case (fld)
          FLD_TGT: tgt   <= wdata[AW-1:0];
          FLD_SRC: src   <= wdata[AW-1:0];
          FLD_LEN: len   <= wdata;
          FLD_DIR: dir_q <= |wdata;
          FLD_TRG: trg_q <= |wdata;
          FLD_ENA: ena_q <= wdata[0];
          FLD_GO:  if ((|wdata) && ena_q && !dir_q) go <= 1'b1;
          default: sus_q <= |wdata;
        endcase
      end
      // write-back placed last: it takes precedence on the fields it updates
      if (done) begin
        tgt <= fin_dst;
        src <= fin_src;
        len <= '0;
        go  <= 1'b0;
        if (keep) ena_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (fld)
      FLD_TGT: rdata = DW'(tgt);
      FLD_SRC: rdata = DW'(src);
      FLD_LEN: rdata = len;
      FLD_DIR: rdata[0] = dir_q;
      FLD_TRG: rdata[0] = trg_q;
      FLD_ENA: rdata[0] = ena_q;
      FLD_GO:  rdata[0] = go;
      default: rdata[0] = sus_q;
    endcase
  end
endmodule

// File: rtl/wcd_arbiter.sv
module wcd_arbiter #(
  parameter int NUM_CH = 4,
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  output logic [CW-1:0]     gnt_idx,
  output logic              any
);
  // fixed priority: scan downward so the lowest set index is assigned last
  always_comb begin
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt_idx = CW'(i);
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wcd_engine.sv
module wcd_engine
  import wcd_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int CW = $clog2(NUM_CH),
  localparam int WB = DW / 8,
  localparam int SH = $clog2(WB)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0]            req,
  input  logic [NUM_CH-1:0][AW-1:0]    ch_src,
  input  logic [NUM_CH-1:0][AW-1:0]    ch_dst,
  input  logic [NUM_CH-1:0][DW-1:0]    ch_len,
  output logic [NUM_CH-1:0]            done,
  output logic [AW-1:0]                fin_src,
  output logic [AW-1:0]                fin_dst,
  output logic                         keep,
  output logic                         mem_rd_valid,
  input  logic                         mem_rd_ready,
  output logic [AW-1:0]                mem_rd_addr,
  input  logic                         mem_rdata_valid,
  input  logic [DW-1:0]                mem_rdata,
  output logic                         mem_wr_valid,
  input  logic                         mem_wr_ready,
  output logic [AW-1:0]                mem_wr_addr,
  output logic [DW-1:0]                mem_wr_data
);
  eng_state_t    st;
  logic [CW-1:0] cur;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] words_q, data_q;
  logic          keep_q;

  logic [CW-1:0] pick;
  logic          pick_any;
  logic [DW-1:0] bytes_n, words_n;

  wcd_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .req     (req),
    .gnt_idx (pick),
    .any     (pick_any)
  );

  // count field excludes the top flag bit; round up to whole words
  assign bytes_n = {1'b0, ch_len[pick][DW-2:0]};
  assign words_n = (bytes_n + DW'(WB - 1)) >> SH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur     <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      words_q <= '0;
      data_q  <= '0;
      keep_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (pick_any) begin
          cur     <= pick;
          src_q   <= ch_src[pick];
          dst_q   <= ch_dst[pick];
          keep_q  <= ch_len[pick][DW-1];
          words_q <= words_n;
          st      <= (words_n == '0) ? ST_DONE : ST_RD;
        end
        ST_RD: if (mem_rd_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rdata_valid) begin
          data_q <= mem_rdata;
          st     <= ST_WR;
        end
        ST_WR: if (mem_wr_ready) begin
          src_q   <= src_q + AW'(WB);
          dst_q   <= dst_q + AW'(WB);
          words_q <= words_q - DW'(1);
          st      <= (words_q == DW'(1)) ? ST_DONE : ST_RD;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    done = '0;
    if (st == ST_DONE) done[cur] = 1'b1;
  end

  assign fin_src      = src_q;
  assign fin_dst      = dst_q;
  assign keep         = keep_q;
  assign mem_rd_valid = (st == ST_RD);
  assign mem_rd_addr  = src_q;
  assign mem_wr_valid = (st == ST_WR);
  assign mem_wr_addr  = dst_q;
  assign mem_wr_data  = data_q;
endmodule

// File: rtl/word_copy_dma.sv
module word_copy_dma
  import wcd_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int CW = $clog2(NUM_CH),
  localparam int RAW = FLD_W + CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic              mem_rdata_valid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [DW-1:0]     mem_wr_data,
  output logic [NUM_CH-1:0] irq
);
  logic [CW-1:0]    sel_ch;
  logic [FLD_W-1:0] sel_fld;

  logic [NUM_CH-1:0][AW-1:0] ch_tgt, ch_src;
  logic [NUM_CH-1:0][DW-1:0] ch_len, ch_rdata;
  logic [NUM_CH-1:0]         ch_go, done;
  logic [AW-1:0]             fin_src, fin_dst;
  logic                      keep;

  assign sel_ch  = reg_addr[RAW-1:FLD_W];
  assign sel_fld = reg_addr[FLD_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wcd_chan_regs #(.AW(AW), .DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && (sel_ch == CW'(c))),
      .fld     (sel_fld),
      .wdata   (reg_wdata),
      .done    (done[c]),
      .fin_src (fin_src),
      .fin_dst (fin_dst),
      .keep    (keep),
      .tgt     (ch_tgt[c]),
      .src     (ch_src[c]),
      .len     (ch_len[c]),
      .go      (ch_go[c]),
      .rdata   (ch_rdata[c]),
      .irq     (irq[c])
    );
  end

  assign reg_rdata = ch_rdata[sel_ch];

  wcd_engine #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_eng (
    .clk             (clk),
    .rst_n           (rst_n),
    .req             (ch_go),
    .ch_src          (ch_src),
    .ch_dst          (ch_tgt),
    .ch_len          (ch_len),
    .done            (done),
    .fin_src         (fin_src),
    .fin_dst         (fin_dst),
    .keep            (keep),
    .mem_rd_valid    (mem_rd_valid),
    .mem_rd_ready    (mem_rd_ready),
    .mem_rd_addr     (mem_rd_addr),
    .mem_rdata_valid (mem_rdata_valid),
    .mem_rdata       (mem_rdata),
    .mem_wr_valid    (mem_wr_valid),
    .mem_wr_ready    (mem_wr_ready),
    .mem_wr_addr     (mem_wr_addr),
    .mem_wr_data     (mem_wr_data)
  );
endmodule

// File: rtl/wcd_checker.sv
module wcd_checker #(
  parameter int NUM_CH = 4,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [AW-1:0]     mem_rd_addr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [AW-1:0]     mem_wr_addr,
  input logic [DW-1:0]     mem_wr_data,
  input logic [NUM_CH-1:0] irq
);
  // R11: a stalled read request is held unchanged
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R11: a stalled write request is held unchanged
  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R4: reads and writes never requested together
  p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_valid && mem_wr_valid));

  // R9: one channel completes at a time
  p_irq_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  // R7: completion interrupt lasts a single cycle
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |=> (irq == '0));
endmodule

bind word_copy_dma wcd_checker #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .irq          (irq)
);

// File: tb/word_copy_dma_test.sv
module word_copy_dma_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_rd_valid, mem_wr_valid;
  logic        mem_rd_ready = 1'b0, mem_wr_ready = 1'b0;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic        mem_rdata_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  irq;

  int checks = 0, fails = 0, cyc = 0;
  int rd_hs = 0, wr_hs = 0;
  int irq_log [0:15];
  int irq_cnt = 0;
  logic        stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] mem [0:255];

  word_copy_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0101;
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = pat(i);

  // memory model and monitors
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rd_ready <= stall_en ? lfsr[0] : 1'b1;
    mem_wr_ready <= stall_en ? lfsr[3] : 1'b1;
    mem_rdata_valid <= mem_rd_valid && mem_rd_ready;
    mem_rdata <= mem[mem_rd_addr[9:2]];
    if (mem_rd_valid && mem_rd_ready) rd_hs <= rd_hs + 1;
    if (mem_wr_valid && mem_wr_ready) begin
      mem[mem_wr_addr[9:2]] <= mem_wr_data;
      wr_hs <= wr_hs + 1;
    end
    if (rst_n && irq != 4'd0 && irq_cnt < 16) begin
      for (int i = 0; i < 4; i++) if (irq[i]) irq_log[irq_cnt] <= i;
      irq_cnt <= irq_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int ch, input logic [2:0] fld, input logic [31:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {ch[1:0], fld}; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int ch, input logic [2:0] fld, output logic [31:0] val);
    reg_addr = {ch[1:0], fld};
    #1 val = reg_rdata;
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d, input logic [31:0] l);
    wr_reg(ch, 3'd0, d);
    wr_reg(ch, 3'd1, s);
    wr_reg(ch, 3'd2, l);
    wr_reg(ch, 3'd3, 0);
    wr_reg(ch, 3'd5, 1);
  endtask

  task automatic wait_irq(input int ch, input string req);
    int n = 0;
    while (!irq[ch] && n < 3000) begin @(negedge clk); n++; end
    chk(req, {31'd0, irq[ch]}, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 8; f++) begin
        rd_reg(c, f[2:0], v);
        chk("R1 reg", v, 0);
      end
    chk("R1 irq", {28'd0, irq}, 0);
    chk("R1 req", {30'd0, mem_rd_valid, mem_wr_valid}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr_reg(3, 3'd0, 32'h1234_5678); rd_reg(3, 3'd0, v); chk("R2 tgt", v, 32'h1234_5678);
    wr_reg(3, 3'd3, 5);  rd_reg(3, 3'd3, v); chk("R2 dir", v, 1);
    wr_reg(3, 3'd4, 8);  rd_reg(3, 3'd4, v); chk("R2 trg", v, 1);
    wr_reg(3, 3'd7, 2);  rd_reg(3, 3'd7, v); chk("R2 sus", v, 1);
    wr_reg(3, 3'd5, 3);  rd_reg(3, 3'd5, v); chk("R2 ena", v, 1);
    wr_reg(3, 3'd3, 0); wr_reg(3, 3'd4, 0); wr_reg(3, 3'd7, 0); wr_reg(3, 3'd5, 0);
  endtask

  task automatic t_refused;
    logic [31:0] v;
    int r0, w0, i0;
    r0 = rd_hs; w0 = wr_hs; i0 = irq_cnt;
    setup(1, 32'h0, 32'h200, 16);
    wr_reg(1, 3'd5, 0);
    wr_reg(1, 3'd6, 1);  rd_reg(1, 3'd6, v); chk("R3 disabled", v, 0);
    wr_reg(1, 3'd5, 1); wr_reg(1, 3'd3, 1);
    wr_reg(1, 3'd6, 1);  rd_reg(1, 3'd6, v); chk("R3 direction", v, 0);
    wr_reg(1, 3'd3, 0);
    wr_reg(1, 3'd6, 0);  rd_reg(1, 3'd6, v); chk("R3 zero write", v, 0);
    repeat (10) @(negedge clk);
    chk("R3 no traffic", rd_hs + wr_hs, r0 + w0);
    chk("R3 no irq", irq_cnt, i0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    stall_en = 1'b1;
    setup(1, 32'h0, 32'h200, 16);
    wr_reg(1, 3'd6, 1);
    rd_reg(1, 3'd1, v); chk("R10 src", v, 32'h0);
    rd_reg(1, 3'd2, v); chk("R10 len", v, 16);
    rd_reg(1, 3'd6, v); chk("R3 start", v, 1);
    wait_irq(1, "R7 irq1");
    rd_reg(1, 3'd0, v); chk("R7 tgt", v, 32'h210);
    rd_reg(1, 3'd1, v); chk("R5 src", v, 32'h10);
    rd_reg(1, 3'd2, v); chk("R5 len", v, 0);
    rd_reg(1, 3'd6, v); chk("R5 start", v, 0);
    rd_reg(1, 3'd5, v); chk("R6 ena kept", v, 1);
    @(negedge clk); chk("R7 pulse", {28'd0, irq}, 0);
    for (int i = 0; i < 4; i++) chk("R4 data", mem[8'h80 + i], pat(i));
    stall_en = 1'b0;
  endtask

  task automatic t_keep;
    logic [31:0] v;
    setup(2, 32'h40, 32'h240, 32'h8000_0006);
    wr_reg(2, 3'd6, 1);
    wr_reg(2, 3'd5, 0);
    wait_irq(2, "R6 irq2");
    rd_reg(2, 3'd5, v); chk("R6 ena forced", v, 1);
    rd_reg(2, 3'd1, v); chk("R5 round src", v, 32'h48);
    rd_reg(2, 3'd0, v); chk("R5 round tgt", v, 32'h248);
    chk("R4 w0", mem[8'h90], pat(16));
    chk("R4 w1", mem[8'h91], pat(17));
    chk("R5 beyond", mem[8'h92], pat(8'h92));
    setup(3, 32'h80, 32'h280, 4);
    wr_reg(3, 3'd6, 1);
    wr_reg(3, 3'd5, 0);
    wait_irq(3, "R6 irq3");
    rd_reg(3, 3'd5, v); chk("R6 ena cleared", v, 0);
    chk("R4 single", mem[8'hA0], pat(32));
  endtask

  task automatic t_zero;
    logic [31:0] v;
    int r0, w0;
    r0 = rd_hs; w0 = wr_hs;
    setup(0, 32'h100, 32'h300, 0);
    wr_reg(0, 3'd6, 1);
    wait_irq(0, "R8 irq0");
    rd_reg(0, 3'd1, v); chk("R8 src", v, 32'h100);
    rd_reg(0, 3'd0, v); chk("R8 tgt", v, 32'h300);
    rd_reg(0, 3'd6, v); chk("R8 start", v, 0);
    chk("R8 traffic", rd_hs + wr_hs, r0 + w0);
  endtask

  task automatic t_arb;
    int n = 0;
    int base;
    stall_en = 1'b1;
    setup(2, 32'h0, 32'h300, 32);
    setup(3, 32'h10, 32'h380, 4);
    setup(1, 32'h20, 32'h3C0, 8);
    base = irq_cnt;
    wr_reg(2, 3'd6, 1);
    wr_reg(3, 3'd6, 1);
    wr_reg(1, 3'd6, 1);
    while (irq_cnt < base + 3 && n < 5000) begin @(negedge clk); n++; end
    chk("R9 count", irq_cnt, base + 3);
    chk("R9 first", irq_log[base], 2);
    chk("R9 second", irq_log[base + 1], 1);
    chk("R9 third", irq_log[base + 2], 3);
    for (int i = 0; i < 8; i++) chk("R4 long", mem[8'hC0 + i], pat(i));
    chk("R4 ch3", mem[8'hE0], pat(4));
    chk("R4 ch1", mem[8'hF1], pat(9));
    stall_en = 1'b0;
  endtask

  task automatic collide(input logic [31:0] dst, input int ch_w, input logic [2:0] fld,
                         input logic [31:0] val);
    int n = 0;
    wr_reg(0, 3'd6, 1);
    while (!(mem_wr_valid && mem_wr_ready && mem_wr_addr == dst + 4) && n < 2000) begin
      @(negedge clk); n++;
    end
    @(posedge clk);
    #1 reg_wr = 1'b1; reg_addr = {ch_w[1:0], fld}; reg_wdata = val;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic t_collide;
    logic [31:0] v;
    setup(1, 32'h34, 32'h140, 4);
    setup(0, 32'h30, 32'h100, 8);
    collide(32'h100, 1, 3'd6, 1);
    wait_irq(1, "R12 late start");
    chk("R12 data", mem[8'h50], pat(13));
    rd_reg(0, 3'd1, v); chk("R12 src0", v, 32'h38);
    setup(0, 32'h30, 32'h180, 8);
    collide(32'h180, 0, 3'd1, 32'hFFF0);
    @(negedge clk);
    rd_reg(0, 3'd1, v); chk("R12 precedence", v, 32'h38);
    rd_reg(0, 3'd0, v); chk("R12 tgt", v, 32'h188);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_refused;
    t_basic;
    t_keep;
    t_zero;
    t_arb;
    t_collide;
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule